// File: doc/BRIEF.md
# DMA Transfer Chunker and Completion Tracker

This block takes one DMA command at a time: a start address, a byte length, a read/write flag and a completion delay in cycles. It cuts the command into memory requests that each stay inside one aligned block of `BLK_BYTES` bytes. The first request runs from the start address up to the next block boundary, the middle requests are whole blocks, and the last request carries whatever remains. Each request also carries the byte offset of its data within the command, so a data mover can index its buffer without doing any arithmetic of its own.

The block counts outstanding requests. It adds the acknowledged sizes that come back on the response input and raises a completion pulse when the acknowledged total equals the command length. The pulse comes in the same cycle as the last response, or a programmed number of cycles later. A response that would take the acknowledged total past the length, or that arrives while nothing is outstanding, raises an error pulse. A drain handshake answers at once when nothing is in flight. Otherwise it remembers the request and pulses when the last outstanding request has been answered.

Top module: `dma_chunker`

## Requirements
- R1: Every request lies inside one aligned block. The first request runs from the command address to the next multiple of `BLK_BYTES` (or to the end of the command), later requests start on a boundary, and the sizes add up to the command length. Requests come out one per cycle, starting the cycle after the command is accepted.
- R2: `chk_offset` of each request equals the sum of the sizes of the requests emitted before it for the same command, so it is 0 for the first request.
- R3: `pend_cnt` goes up by one for each request emitted and down by one for each accepted response. After all requests of a command are out and before any response arrives, it equals the number of requests.
- R4: With a delay of 0, `done` is high in the same cycle as the response that brings the acknowledged total to the command length, and in no other cycle of that command.
- R5: With a delay of D > 0, `done` is high only in the D-th cycle after the cycle of the final response.
- R6: A command of length 0 raises `done` in its acceptance cycle, whatever its delay, and emits no request.
- R7: `cmd_ready` is low from the cycle after a non-zero-length command is accepted until the cycle after its `done` pulse. It is high out of reset.
- R8: `drain_idle` is high in the same cycle as `drain_req` when `pend_cnt` is 0. In that case no `drained` pulse follows.
- R9: A `drain_req` made while requests are outstanding gives a single one-cycle `drained` pulse in the first cycle in which `pend_cnt` is 0.
- R10: A response whose size would take the acknowledged total past the command length raises `rsp_err` in that cycle, and `done` stays low.
- R11: A response while `pend_cnt` is 0 raises `rsp_err` in that cycle and leaves `pend_cnt` at 0.
- R12: After reset, `cmd_ready` is 1 and `chk_valid`, `pend_cnt`, `done`, `rsp_err` and `drained` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Length in bytes |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_delay | input | DLY_W | Completion delay in cycles |
| chk_valid | output | 1 | Request emitted this cycle |
| chk_addr | output | ADDR_W | Request address |
| chk_size | output | SZ_W | Request size in bytes |
| chk_offset | output | LEN_W | Data offset within the command |
| chk_write | output | 1 | Request direction |
| rsp_valid | input | 1 | Response arrives |
| rsp_size | input | SZ_W | Bytes acknowledged |
| done | output | 1 | Command completion pulse |
| rsp_err | output | 1 | Overflow or stray response pulse |
| pend_cnt | output | LEN_W+1 | Outstanding requests |
| drain_req | input | 1 | Drain request pulse |
| drain_idle | output | 1 | Drain answered at once |
| drained | output | 1 | Deferred drain completion pulse |

## Verification
The first request is due one clock after acceptance and the rest follow on consecutive cycles. The bench therefore drives the command on a falling edge and samples each request one falling edge later, comparing it with chunks it computes by modular arithmetic. `done` (delay 0), `rsp_err`, `drain_idle` and zero-length completion are combinational on the inputs, so they are sampled 1 ns after the inputs are driven in that same cycle. A delayed `done` and the deferred `drained` pulse are sampled at each of the following falling edges. Each of these is checked to be high in exactly the cycle where it is due and low in the cycles around it. The sweep covers every start offset in two blocks against lengths at and around block multiples, with delays from 0 to 7.

// File: rtl/dma_chunk_pkg.sv
// Package: shared types for the chunker. Assumes nothing.
package dma_chunk_pkg;
    // Completion tracker states
    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_ACC  = 2'd1,
        TRK_WAIT = 2'd2
    } trk_state_e;
endpackage

// File: rtl/dma_chunk_gen.sv
// Splits one command into block-bounded requests, one per cycle.
// Assumes: BLK_BYTES is a power of two, LEN_W >= log2(BLK_BYTES)+1,
// and load is only pulsed while busy is low.
module dma_chunk_gen #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 12,
    parameter int BLK_BYTES = 64,
    localparam int OFS_W    = $clog2(BLK_BYTES),
    localparam int SZ_W     = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_write,
    output logic              busy,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SZ_W-1:0]   out_size,
    output logic [LEN_W-1:0]  out_offset,
    output logic              out_write
);
    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  off_q;
    logic              wr_q;
    logic [SZ_W-1:0]   room;

    // Bytes left to the next boundary, and the size of this request
    always_comb begin
        room     = SZ_W'(BLK_BYTES) - SZ_W'(addr_q[OFS_W-1:0]);
        out_size = (rem_q < LEN_W'(room)) ? SZ_W'(rem_q) : room;
    end

    assign busy       = busy_q;
    assign out_addr   = addr_q;
    assign out_offset = off_q;
    assign out_write  = wr_q;

    // Load a command, then step through its requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            off_q  <= '0;
            wr_q   <= 1'b0;
        end else if (load && ld_len != '0) begin
            busy_q <= 1'b1;
            addr_q <= ld_addr;
            rem_q  <= ld_len;
            off_q  <= '0;
            wr_q   <= ld_write;
        end else if (busy_q) begin
            addr_q <= addr_q + ADDR_W'(out_size);
            rem_q  <= rem_q - LEN_W'(out_size);
            off_q  <= off_q + LEN_W'(out_size);
            if (rem_q == LEN_W'(out_size))
                busy_q <= 1'b0;
        end
    end

    // R1
    chunk_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (out_size != '0 &&
                  (SZ_W'(out_addr[OFS_W-1:0]) + out_size) <= SZ_W'(BLK_BYTES)));
    // R2
    offset_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            out_offset == $past(out_offset) + LEN_W'($past(out_size)));
    // R1
    addr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            out_addr == $past(out_addr) + ADDR_W'($past(out_size)));
endmodule

// File: rtl/dma_pend_track.sv
// Outstanding-request counter with the drain handshake.
// Assumes: inc rises at most once per cycle, and responses never
// outnumber requests on a correct bus (stray ones are flagged).
module dma_pend_track #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             rsp_valid,
    input  logic             drain_req,
    output logic [CNT_W-1:0] cnt,
    output logic             stray,
    output logic             drain_idle,
    output logic             drained
);
    logic [CNT_W-1:0] cnt_q;
    logic             drain_pend_q;
    logic             dec;

    // Decrement only when something is outstanding
    always_comb begin
        dec        = rsp_valid && cnt_q != '0;
        stray      = rsp_valid && cnt_q == '0;
        drain_idle = drain_req && cnt_q == '0;
        drained    = drain_pend_q && cnt_q == '0;
    end

    assign cnt = cnt_q;

    // Count requests in and responses back
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && !dec)
            cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc)
            cnt_q <= cnt_q - 1'b1;
    end

    // Hold a drain request until the counter is empty
    always_ff @(posedge clk) begin
        if (!rst_n)
            drain_pend_q <= 1'b0;
        else if (drained)
            drain_pend_q <= 1'b0;
        else if (drain_req && cnt_q != '0)
            drain_pend_q <= 1'b1;
    end

    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !inc) |=> cnt_q == '0);
    // R9
    drained_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drained |=> !drained);
    // R8
    idle_not_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_idle && !drain_pend_q) |=> !drained);
endmodule

// File: rtl/dma_done_track.sv
// Adds up acknowledged bytes and raises completion, at once or after
// a programmed delay. Assumes start only while the tracker is idle.
module dma_done_track
    import dma_chunk_pkg::*;
#(
    parameter int LEN_W = 12,
    parameter int SZ_W  = 7,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] st_len,
    input  logic [DLY_W-1:0] st_delay,
    input  logic             rsp_valid,
    input  logic [SZ_W-1:0]  rsp_size,
    output logic             active,
    output logic             done,
    output logic             ovf
);
    trk_state_e       st_q;
    logic [LEN_W-1:0] total_q;
    logic [LEN_W-1:0] acc_q;
    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [LEN_W:0]   sum;
    logic             hit;

    // Running total and completion decode
    always_comb begin
        sum    = {1'b0, acc_q} + (LEN_W+1)'(rsp_size);
        hit    = st_q == TRK_ACC && rsp_valid && sum == {1'b0, total_q};
        ovf    = st_q == TRK_ACC && rsp_valid && sum > {1'b0, total_q};
        active = st_q != TRK_IDLE;
        done   = (start && st_len == '0) || (hit && dly_q == '0) ||
                 (st_q == TRK_WAIT && cnt_q == DLY_W'(1));
    end

    // Tracker state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= TRK_IDLE;
            total_q <= '0;
            acc_q   <= '0;
            dly_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (st_q)
                TRK_IDLE: if (start && st_len != '0) begin
                    st_q    <= TRK_ACC;
                    total_q <= st_len;
                    acc_q   <= '0;
                    dly_q   <= st_delay;
                end
                TRK_ACC: begin
                    if (rsp_valid && !ovf)
                        acc_q <= sum[LEN_W-1:0];
                    if (hit) begin
                        st_q  <= (dly_q == '0) ? TRK_IDLE : TRK_WAIT;
                        cnt_q <= dly_q;
                    end
                end
                TRK_WAIT: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == DLY_W'(1))
                        st_q <= TRK_IDLE;
                end
                default: st_q <= TRK_IDLE;
            endcase
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !hit);
    // R5
    wait_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_WAIT && cnt_q == DLY_W'(1)) |=> st_q == TRK_IDLE);
endmodule

// File: rtl/dma_chunker.sv
// Top: takes one command at a time, emits block-bounded requests,
// tracks outstanding ones and reports completion and drain.
// Assumes: BLK_BYTES is a power of two and LEN_W > log2(BLK_BYTES).
module dma_chunker #(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 12,
    parameter int BLK_BYTES = 64,
    parameter int DLY_W     = 4,
    localparam int SZ_W     = $clog2(BLK_BYTES) + 1,
    localparam int CNT_W    = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_write,
    input  logic [DLY_W-1:0]  cmd_delay,
    output logic              chk_valid,
    output logic [ADDR_W-1:0] chk_addr,
    output logic [SZ_W-1:0]   chk_size,
    output logic [LEN_W-1:0]  chk_offset,
    output logic              chk_write,
    input  logic              rsp_valid,
    input  logic [SZ_W-1:0]   rsp_size,
    output logic              done,
    output logic              rsp_err,
    output logic [CNT_W-1:0]  pend_cnt,
    input  logic              drain_req,
    output logic              drain_idle,
    output logic              drained
);
    logic gen_busy;
    logic trk_active;
    logic accept;
    logic ovf;
    logic stray;

    // One command at a time: accept only when fully idle
    assign cmd_ready = !gen_busy && !trk_active;
    assign accept    = cmd_valid && cmd_ready;
    assign chk_valid = gen_busy;
    assign rsp_err   = ovf || stray;

    dma_chunk_gen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)
    ) gen_i (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .ld_addr(cmd_addr), .ld_len(cmd_len), .ld_write(cmd_write),
        .busy(gen_busy), .out_addr(chk_addr), .out_size(chk_size),
        .out_offset(chk_offset), .out_write(chk_write)
    );

    dma_pend_track #(.CNT_W(CNT_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .inc(gen_busy), .rsp_valid(rsp_valid),
        .drain_req(drain_req), .cnt(pend_cnt), .stray(stray),
        .drain_idle(drain_idle), .drained(drained)
    );

    dma_done_track #(.LEN_W(LEN_W), .SZ_W(SZ_W), .DLY_W(DLY_W)) done_i (
        .clk(clk), .rst_n(rst_n), .start(accept), .st_len(cmd_len),
        .st_delay(cmd_delay), .rsp_valid(rsp_valid), .rsp_size(rsp_size),
        .active(trk_active), .done(done), .ovf(ovf)
    );

    // R7
    busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> !cmd_ready);
    // R6
    zero_len_no_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_len == '0) |=> !chk_valid);
endmodule

// File: tb/dma_chunker_tb.sv
module dma_chunker_tb_top;
    localparam int AW  = 8;
    localparam int LW  = 7;
    localparam int BLK = 16;
    localparam int DW  = 3;
    localparam int SW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic cmd_write = 1'b0;
    logic [DW-1:0] cmd_delay = '0;
    logic chk_valid;
    logic [AW-1:0] chk_addr;
    logic [SW-1:0] chk_size;
    logic [LW-1:0] chk_offset;
    logic chk_write;
    logic rsp_valid = 1'b0;
    logic [SW-1:0] rsp_size = '0;
    logic done, rsp_err, drain_idle, drained;
    logic [LW:0] pend_cnt;
    logic drain_req = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_chunker #(.ADDR_W(AW), .LEN_W(LW), .BLK_BYTES(BLK), .DLY_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write),
        .cmd_delay(cmd_delay), .chk_valid(chk_valid), .chk_addr(chk_addr),
        .chk_size(chk_size), .chk_offset(chk_offset), .chk_write(chk_write),
        .rsp_valid(rsp_valid), .rsp_size(rsp_size), .done(done),
        .rsp_err(rsp_err), .pend_cnt(pend_cnt), .drain_req(drain_req),
        .drain_idle(drain_idle), .drained(drained)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        check(cmd_ready == 1'b1, "R12 cmd_ready", int'(cmd_ready), 1);
        check(chk_valid == 1'b0, "R12 chk_valid", int'(chk_valid), 0);
        check(pend_cnt == '0, "R12 pend_cnt", int'(pend_cnt), 0);
        check(done == 1'b0 && rsp_err == 1'b0 && drained == 1'b0,
              "R12 pulses", int'({done, rsp_err, drained}), 0);
        @(negedge clk);
    endtask

    task automatic run_cmd(input int addr, input int len, input int dly, input bit wr,
                           input bit do_drain);
        int sizes[16];
        int n = 0;
        int a = addr;
        int rem = len;
        int off = 0;
        check(cmd_ready == 1'b1, "R7 ready before cmd", int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_addr = AW'(addr); cmd_len = LW'(len);
        cmd_delay = DW'(dly); cmd_write = wr;
        #1;
        if (len == 0) begin
            // R6 zero-length completes in the acceptance cycle
            check(done == 1'b1, "R6 done on zero length", int'(done), 1);
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            check(chk_valid == 1'b0, "R6 no chunk", int'(chk_valid), 0);
            check(done == 1'b0 && cmd_ready == 1'b1, "R6 after", int'({done, cmd_ready}), 1);
            return;
        end
        check(done == 1'b0, "R4 no done at accept", int'(done), 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (rem > 0) begin
            int sz = BLK - (a % BLK);
            if (rem < sz) sz = rem;
            #1;
            // R1 address and size, R2 offset, R7 ready low
            check(chk_valid == 1'b1, "R1 chk_valid", int'(chk_valid), 1);
            check(int'(chk_addr) == (a % 256), "R1 chk_addr", int'(chk_addr), a % 256);
            check(int'(chk_size) == sz, "R1 chk_size", int'(chk_size), sz);
            check(int'(chk_offset) == off, "R2 chk_offset", int'(chk_offset), off);
            check(chk_write == wr && cmd_ready == 1'b0, "R7 write/ready",
                  int'({chk_write, cmd_ready}), int'({wr, 1'b0}));
            sizes[n] = sz; n++;
            a += sz; rem -= sz; off += sz;
            @(negedge clk);
        end
        #1;
        check(chk_valid == 1'b0, "R1 stream ends", int'(chk_valid), 0);
        // R3 outstanding count equals number of requests
        check(int'(pend_cnt) == n, "R3 pend_cnt full", int'(pend_cnt), n);
        if (do_drain) begin
            drain_req = 1'b1;
            #1;
            check(drain_idle == 1'b0, "R9 no idle when busy", int'(drain_idle), 0);
            @(negedge clk);
            drain_req = 1'b0;
            #1;
            check(drained == 1'b0, "R9 no early drained", int'(drained), 0);
        end
        for (int i = 0; i < n; i++) begin
            rsp_valid = 1'b1; rsp_size = SW'(sizes[i]);
            #1;
            check(int'(pend_cnt) == n - i, "R3 pend_cnt counts down", int'(pend_cnt), n - i);
            check(rsp_err == 1'b0, "R10 no error", int'(rsp_err), 0);
            if (i == n - 1 && dly == 0)
                check(done == 1'b1, "R4 done with last response", int'(done), 1);
            else
                check(done == 1'b0, "R4 no early done", int'(done), 0);
            if (do_drain)
                check(drained == 1'b0, "R9 drained too early", int'(drained), 0);
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        #1;
        if (do_drain)
            check(drained == 1'b1, "R9 drained pulse", int'(drained), 1);
        for (int k = 1; k <= dly; k++) begin
            #1;
            check(done == (k == dly), "R5 delayed done", int'(done), int'(k == dly));
            check(cmd_ready == 1'b0, "R7 ready low while waiting", int'(cmd_ready), 0);
            @(negedge clk);
            if (do_drain && k == 1) begin
                #1;
                check(drained == 1'b0, "R9 single pulse", int'(drained), 0);
            end
        end
        #1;
        check(done == 1'b0, "R5 done is a pulse", int'(done), 0);
        check(cmd_ready == 1'b1 && pend_cnt == '0, "R7 ready after done",
              int'({cmd_ready, pend_cnt}), int'({1'b1, 8'd0}));
        @(negedge clk);
    endtask

    initial begin
        int lens[10] = '{0, 1, 2, 15, 16, 17, 31, 33, 47, 64};
        int di = 0;
        do_reset();
        // R8 idle drain
        drain_req = 1'b1;
        #1;
        check(drain_idle == 1'b1, "R8 drain_idle", int'(drain_idle), 1);
        @(negedge clk);
        drain_req = 1'b0;
        #1;
        check(drained == 1'b0, "R8 no drained after idle", int'(drained), 0);
        @(negedge clk);
        // R11 stray response
        rsp_valid = 1'b1; rsp_size = SW'(4);
        #1;
        check(rsp_err == 1'b1, "R11 stray error", int'(rsp_err), 1);
        @(negedge clk);
        rsp_valid = 1'b0;
        #1;
        check(pend_cnt == '0, "R11 no underflow", int'(pend_cnt), 0);
        @(negedge clk);
        // Sweep start offsets against lengths and delays (R1..R7)
        for (int ad = 0; ad < 2 * BLK + 2; ad++) begin
            for (int li = 0; li < 10; li++) begin
                run_cmd(ad, lens[li], di % 8, 1'((ad + li) % 2), 1'b0);
                di++;
            end
        end
        // R9 deferred drain, with and without delay
        run_cmd(5, 40, 0, 1'b1, 1'b1);
        run_cmd(9, 20, 3, 1'b0, 1'b1);
        // R10 overflow
        run_overflow();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic run_overflow();
        cmd_valid = 1'b1; cmd_addr = AW'(0); cmd_len = LW'(4); cmd_delay = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_size = SW'(6);
        #1;
        check(rsp_err == 1'b1, "R10 overflow error", int'(rsp_err), 1);
        check(done == 1'b0, "R10 no done on overflow", int'(done), 0);
        @(negedge clk);
        rsp_valid = 1'b0;
        do_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule